// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Path

This block is the device-side read path of a large parallel read-only memory that software or a board strap can run either as a 16-bit word memory or as an 8-bit byte memory. It accepts a chip enable, two active-low output enables, an organisation select and the address bus. It drives a 16-bit data bus with one output enable per bit. In byte organisation the top data pin is an input: it carries the lowest address bit, and the upper byte lanes are left undriven. Neither output enable acts as a plain output enable. Exactly one of them must be low, and which one is low chooses the lower or upper half of the array. The two pins therefore act as the most significant address bit.

A small internal array stands in for the full array. Its contents come from a pure function of the byte address. Access latency is counted in clock cycles. A change of page (any address bit above the page offset, the half select or the organisation) waits the random-access count. A change within the page offset waits only the shorter page count. While data is not yet valid, the enabled lanes drive zero and the valid flag stays low.

Top module: `rdp_rom_read`

## Requirements
- R1: In word organisation (`org_word`=1) the word address is {half, `addr`}. Once `valid` is high, `dout` = {pat(2w+1), pat(2w)}, where w is that word address and pat(b) = ((29·b) mod 256) XOR ((b div 8) mod 256) XOR 0xA5. All 16 `dout_en` bits are 1.
- R2: In byte organisation (`org_word`=0) the byte address is {half, `addr`, `lsb_in`}. Once `valid` is high, `dout[7:0]` = pat(byte address), `dout[15:8]` = 0 and `dout_en` = 16'h00FF (bits 8 to 15 undriven; bit 15 is the address input).
- R3: With `ce_n`=0, `oe_lo_n`=0 and `oe_hi_n`=1, half = 0 (lower half). With `oe_lo_n`=1 and `oe_hi_n`=0, half = 1 (upper half).
- R4: With `ce_n`=0 and both output enables high, `dout_en`=0, `dout`=0, `valid`=0 and `err`=0.
- R5: With `ce_n`=1, `dout_en`=0, `dout`=0, `valid`=0 and `err`=0, whatever the other inputs are.
- R6: With `ce_n`=0 and both output enables low, `err`=1, `dout_en`=0 and `valid`=0.
- R7: After a read becomes active, or after a change of half, organisation or any address bit above the page offset (`addr[PAGE_W-1:0]`), `valid` is 0 until RAND_LAT rising edges have passed and 1 from then on. During the wait the enabled lanes drive 0.
- R8: A change confined to the page offset (`addr[PAGE_W-1:0]`, plus `lsb_in` in byte organisation) drops `valid` and raises it again after PAGE_LAT rising edges.
- R9: In word organisation `lsb_in` has no effect: toggling it leaves `valid` high and `dout` unchanged.
- R10: After reset with `ce_n`=1, `valid`=0 and `dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Latency counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_lo_n | input | 1 | Active-low enable, selects the lower half |
| oe_hi_n | input | 1 | Active-low enable, selects the upper half |
| org_word | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| addr | input | ADDR_W | Word address within a half |
| lsb_in | input | 1 | Lowest byte address bit (shares the top data pin) |
| dout | output | 16 | Data bus |
| dout_en | output | 16 | Per-bit drive enable (0 = high impedance) |
| valid | output | 1 | Data on the enabled lanes is valid |
| err | output | 1 | Both output enables are low while the chip is enabled |

## Verification
Word organisation is swept in ascending address order over both halves. Each step then checks the latency against the page boundary: inside a page only the short count applies, and crossing a page or half applies the long one. Byte organisation is swept over every byte address, which checks the lane choice by the lowest bit and the undriven upper lanes. Control-pin patterns (standby, both enables high, both low) are applied on top of a valid read to separate the three high-impedance cases and the error flag. Toggling the lowest address bit in word organisation shows that it is ignored there.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  // Deterministic array contents: a pure function of the byte address
  function automatic logic [7:0] pat_byte(input int unsigned ba);
    int unsigned m;
    m = ba * 29;
    return 8'(m) ^ 8'(ba >> 3) ^ 8'hA5;
  endfunction
endpackage

// File: rtl/rdp_addr_path.sv
module rdp_addr_path #(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 3,
  localparam int BYTE_AW = ADDR_W + 2,
  localparam int PKEY_W = ADDR_W - PAGE_W + 2
) (
  input  logic               ce_n,
  input  logic               oe_lo_n,
  input  logic               oe_hi_n,
  input  logic               org_word,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               lsb_in,
  output logic               active,
  output logic               conflict,
  output logic [BYTE_AW-1:0] byte_addr,
  output logic [PKEY_W-1:0]  page_key,
  output logic [PAGE_W:0]    off_key
);
  logic half;
  logic lsb_eff;

  // exactly one output enable low -> active; that pin names the half
  assign active   = !ce_n && (oe_lo_n ^ oe_hi_n);
  assign conflict = !ce_n && !oe_lo_n && !oe_hi_n;
  assign half     = oe_lo_n;
  assign lsb_eff  = org_word ? 1'b0 : lsb_in;

  assign byte_addr = {half, addr, lsb_eff};
  assign page_key  = {org_word, half, addr[ADDR_W-1:PAGE_W]};
  assign off_key   = {addr[PAGE_W-1:0], lsb_eff};
endmodule

// File: rtl/rdp_cell_array.sv
module rdp_cell_array
  import rdp_pkg::*;
#(
  parameter int BYTE_AW = 8,
  localparam int N_BYTES = 1 << BYTE_AW
) (
  input  logic [BYTE_AW-1:0] byte_addr,
  output logic [7:0]         byte_rd,
  output logic [15:0]        word_rd
);
  logic [7:0] mem [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_cell
    assign mem[i] = pat_byte(i);
  end

  assign byte_rd = mem[byte_addr];
  assign word_rd = {mem[{byte_addr[BYTE_AW-1:1], 1'b1}],
                    mem[{byte_addr[BYTE_AW-1:1], 1'b0}]};
endmodule

// File: rtl/rdp_lat_timer.sv
module rdp_lat_timer #(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 3,
  parameter int RAND_LAT = 4,
  parameter int PAGE_LAT = 2,
  localparam int PKEY_W = ADDR_W - PAGE_W + 2,
  localparam int CW = $clog2(RAND_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [PKEY_W-1:0] page_key,
  input  logic [PAGE_W:0]   off_key,
  output logic              valid,
  output logic              new_page,
  output logic              new_off
);
  logic [PKEY_W-1:0] page_q;
  logic [PAGE_W:0]   off_q;
  logic              act_q;
  logic [CW-1:0]     cnt_q;

  assign new_page = !act_q || (page_key != page_q);
  assign new_off  = off_key != off_q;
  assign valid    = active && !new_page && !new_off && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      page_q <= page_key;
      off_q  <= off_key;
      act_q  <= active;
      if (active) begin
        if (new_page)          cnt_q <= CW'(RAND_LAT - 1);
        else if (new_off)      cnt_q <= CW'(PAGE_LAT - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  if (RAND_LAT > 1) begin : g_rand_chk
    AST_NEWPAGE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (active && new_page) |=> !valid); // R7
  end
  if (PAGE_LAT > 1) begin : g_page_chk
    AST_PAGE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !new_page && new_off) |=> !valid); // R8
  end
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !valid); // R5
endmodule

// File: rtl/rdp_lane_mux.sv
module rdp_lane_mux (
  input  logic        active,
  input  logic        valid,
  input  logic        org_word,
  input  logic [7:0]  byte_rd,
  input  logic [15:0] word_rd,
  output logic [15:0] dout,
  output logic [15:0] dout_en
);
  always_comb begin
    dout    = '0;
    dout_en = '0;
    if (active) begin
      if (org_word) begin
        dout_en = 16'hFFFF;
        if (valid) dout = word_rd;
      end else begin
        dout_en = 16'h00FF;
        if (valid) dout[7:0] = byte_rd;
      end
    end
  end

  always_comb begin
    if (!org_word) AST_BYTE_UPPER_HIZ: assert (dout_en[15:8] == 8'h00); // R2
  end
endmodule

// File: rtl/rdp_rom_read.sv
module rdp_rom_read #(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 3,
  parameter int RAND_LAT = 4,
  parameter int PAGE_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_lo_n,
  input  logic              oe_hi_n,
  input  logic              org_word,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsb_in,
  output logic [15:0]       dout,
  output logic [15:0]       dout_en,
  output logic              valid,
  output logic              err
);
  localparam int BYTE_AW = ADDR_W + 2;
  localparam int PKEY_W = ADDR_W - PAGE_W + 2;

  logic               active;
  logic               conflict;
  logic [BYTE_AW-1:0] byte_addr;
  logic [PKEY_W-1:0]  page_key;
  logic [PAGE_W:0]    off_key;
  logic [7:0]         byte_rd;
  logic [15:0]        word_rd;
  logic               new_page;
  logic               new_off;

  rdp_addr_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .ce_n(ce_n), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n), .org_word(org_word),
    .addr(addr), .lsb_in(lsb_in), .active(active), .conflict(conflict),
    .byte_addr(byte_addr), .page_key(page_key), .off_key(off_key));

  rdp_cell_array #(.BYTE_AW(BYTE_AW)) u_cells (
    .byte_addr(byte_addr), .byte_rd(byte_rd), .word_rd(word_rd));

  rdp_lat_timer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RAND_LAT(RAND_LAT),
                  .PAGE_LAT(PAGE_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .page_key(page_key),
    .off_key(off_key), .valid(valid), .new_page(new_page), .new_off(new_off));

  rdp_lane_mux u_mux (
    .active(active), .valid(valid), .org_word(org_word), .byte_rd(byte_rd),
    .word_rd(word_rd), .dout(dout), .dout_en(dout_en));

  assign err = conflict;

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (dout_en == 16'h0 && !err)); // R5
  AST_CONFLICT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_lo_n && !oe_hi_n) |-> (err && dout_en == 16'h0)); // R6
  AST_BOTH_HIGH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_lo_n && oe_hi_n) |-> (dout_en == 16'h0 && !err)); // R4
  AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && org_word) |-> (dout_en == 16'hFFFF)); // R1
endmodule

// File: tb/sim_rdp_rom_read.sv
module sim_rdp_rom_read;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int PAGE_W = 3;
  localparam int RAND_LAT = 4;
  localparam int PAGE_LAT = 2;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_lo_n = 1, oe_hi_n = 1, org_word = 1, lsb_in = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dout, dout_en;
  logic valid, err;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdp_rom_read #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .RAND_LAT(RAND_LAT),
                 .PAGE_LAT(PAGE_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n),
    .org_word(org_word), .addr(addr), .lsb_in(lsb_in), .dout(dout),
    .dout_en(dout_en), .valid(valid), .err(err));

  function automatic int expect_byte(input int b);
    return ((b * 29) % 256) ^ ((b / 8) % 256) ^ 165;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply a read and check latency and result; lat = expected edge count
  task automatic do_read(input bit wmode, input bit half, input int a,
                         input bit lsb, input int lat, input string req);
    int exp_data, exp_en, w, b;
    @(negedge clk);
    org_word = wmode; addr = ADDR_W'(a); lsb_in = lsb;
    oe_lo_n = half; oe_hi_n = !half; ce_n = 0;
    repeat (lat - 1) @(posedge clk);
    #1 chk({req, " still waiting"}, {31'd0, valid}, 0);
    chk({req, " zero while waiting"}, dout, 0);
    @(posedge clk); #1;
    if (wmode) begin
      w = (int'(half) << ADDR_W) + a;
      exp_data = (expect_byte(2*w+1) << 8) | expect_byte(2*w);
      exp_en = 16'hFFFF;
    end else begin
      b = (int'(half) << (ADDR_W+1)) + 2*a + int'(lsb);
      exp_data = expect_byte(b);
      exp_en = 16'h00FF;
    end
    chk({req, " valid"}, {31'd0, valid}, 1);
    chk({req, " data"}, dout, exp_data);
    chk({req, " lanes"}, dout_en, exp_en);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    #1 chk("R10 valid after reset", {31'd0, valid}, 0);
    chk("R10 lanes after reset", dout_en, 0);
    @(negedge clk) rst_n = 1;

    // R1/R3/R7/R8: word sweep, both halves
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        lat = (a % (1 << PAGE_W) == 0) ? RAND_LAT : PAGE_LAT;
        do_read(1, h[0], a, 0, lat, (lat == RAND_LAT) ? "R1 R3 R7 word" : "R1 R3 R8 word");
      end

    // R2/R8: byte sweep over every byte address
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < (1 << ADDR_W); a++)
        for (int l = 0; l < 2; l++) begin
          lat = (a % (1 << PAGE_W) == 0 && l == 0) ? RAND_LAT : PAGE_LAT;
          do_read(0, h[0], a, l[0], lat, "R2 R8 byte");
        end

    // R9: lsb_in ignored in word mode
    do_read(1, 0, 5, 0, RAND_LAT, "R1 setup");
    @(negedge clk) lsb_in = 1;
    @(posedge clk); #1;
    chk("R9 valid kept", {31'd0, valid}, 1);
    chk("R9 data kept", dout, (expect_byte(11) << 8) | expect_byte(10));

    // R4: both enables high
    @(negedge clk) oe_lo_n = 1; oe_hi_n = 1;
    #1 chk("R4 lanes", dout_en, 0);
    chk("R4 data", dout, 0);
    chk("R4 err", {31'd0, err}, 0);
    chk("R4 valid", {31'd0, valid}, 0);

    // R6: both enables low
    @(negedge clk) oe_lo_n = 0; oe_hi_n = 0;
    #1 chk("R6 err", {31'd0, err}, 1);
    chk("R6 lanes", dout_en, 0);
    chk("R6 valid", {31'd0, valid}, 0);

    // R5: standby overrides everything
    @(negedge clk) ce_n = 1;
    #1 chk("R5 lanes", dout_en, 0);
    chk("R5 err", {31'd0, err}, 0);
    chk("R5 valid", {31'd0, valid}, 0);
    chk("R5 data", dout, 0);

    // R7: reactivation waits the long count
    do_read(1, 1, 3, 0, RAND_LAT, "R7 reactivate");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule